// File: doc/BRIEF.md
# Indirect Register Access Port

This block sits between a byte-wide host bus and an internal 8-bit register space. The host never addresses a register directly. It writes a command byte to a control location. It then writes the register address, and for a store also the value, to a data location. The port turns that byte sequence into a single-cycle read or write strobe on an internal register bus. A read result is placed back at the data location for the host to collect.

Two flags pace the host. The input-busy flag says that the last byte written is still being taken in, so the host must wait before writing again. The result-ready flag says that a read value is waiting at the data location. A third status bit records whether the most recent accepted byte went to the control location. A stray data byte is dropped. A fresh command byte, or an unknown one, resets the sequence, so a malformed exchange cannot leave the port stuck.

Top module: `idx_reg_port`

## Requirements
- R1: After reset, the input-busy flag, the result-ready flag and the command flag are all 0, no strobe is active, and the sequencer waits for a command.
- R2: Host offset 4 reads as status with result-ready in bit 0, input-busy in bit 1, the command flag in bit 3 and zeros elsewhere. Host offset 0 reads as the result byte. Any other offset reads as 0, and a write to any other offset is ignored.
- R3: A host write to offset 0 or 4 that is accepted sets input-busy on the next cycle. Input-busy stays set for exactly BUSY_CYCLES cycles and then clears.
- R4: A host write made while input-busy is set is dropped, and it changes no flag or sequence state.
- R5: Command 0x80 written to offset 4, followed by an address byte written to offset 0, gives one read strobe carrying that address in the second cycle after the address write. In the following cycle the addressed value appears at offset 0 and result-ready is set.
- R6: Command 0x81 followed by an address byte and then a value byte gives one write strobe carrying that address and value in the second cycle after the value write.
- R7: A host read of offset 0 clears result-ready on the next cycle, unless a new result is captured on the same edge.
- R8: A data byte written to offset 0 with no command pending causes no strobe.
- R9: A new command byte discards any partial sequence. The bytes written after it follow the new command only.
- R10: A command code other than 0x80 or 0x81 is discarded and returns the sequencer to waiting for a command. Data bytes written after it cause no strobe.
- R11: An accepted write to offset 4 sets the command flag, and an accepted write to offset 0 clears it.
- R12: Each strobe lasts one cycle, and the read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host byte offset (0 data, 4 status/control) |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the current offset |
| reg_addr | output | 8 | Internal register address |
| reg_wdata | output | 8 | Internal register write value |
| reg_wr_stb | output | 1 | Single-cycle internal write strobe |
| reg_rd_stb | output | 1 | Single-cycle internal read strobe |
| reg_rdata | input | 8 | Internal register read value, valid while reg_rd_stb is high |

## Verification
The bench targets writes issued while input-busy is still high. A design that accepted them would see its pending byte overwritten and would strobe with the wrong address. It also aborts a store after the address byte with a new read command. A design that kept the old sequence would emit a spurious write strobe. Unknown command codes and stray data bytes are checked by watching for strobes that must not appear. Reads of the result location are checked so that a stale result-ready flag, or a result captured one cycle off, shows up as a per-cycle mismatch against the behavioural model.

// File: rtl/idxp_pkg.sv
package idxp_pkg;

  localparam logic [7:0] CMD_READ  = 8'h80;
  localparam logic [7:0] CMD_WRITE = 8'h81;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_RD_ADDR = 2'd1,
    SQ_WR_ADDR = 2'd2,
    SQ_WR_DATA = 2'd3
  } seq_state_t;

  typedef struct packed {
    seq_state_t nxt;
    logic       fire_rd;
    logic       fire_wr;
    logic       take_addr;
    logic       take_data;
  } seq_step_t;

  // One consumed byte moves the sequencer one step.
  function automatic seq_step_t seq_step(input seq_state_t cur,
                                         input logic       is_cmd,
                                         input logic [7:0] b);
    seq_step_t s;
    s = '{nxt: cur, fire_rd: 1'b0, fire_wr: 1'b0,
          take_addr: 1'b0, take_data: 1'b0};
    if (is_cmd) begin
      if (b == CMD_READ)       s.nxt = SQ_RD_ADDR;
      else if (b == CMD_WRITE) s.nxt = SQ_WR_ADDR;
      else                     s.nxt = SQ_IDLE;
    end else begin
      unique case (cur)
        SQ_IDLE:    s.nxt = SQ_IDLE;
        SQ_RD_ADDR: begin
          s.take_addr = 1'b1;
          s.fire_rd   = 1'b1;
          s.nxt       = SQ_IDLE;
        end
        SQ_WR_ADDR: begin
          s.take_addr = 1'b1;
          s.nxt       = SQ_WR_DATA;
        end
        SQ_WR_DATA: begin
          s.take_data = 1'b1;
          s.fire_wr   = 1'b1;
          s.nxt       = SQ_IDLE;
        end
        default:    s.nxt = SQ_IDLE;
      endcase
    end
    return s;
  endfunction

  function automatic logic [7:0] status_byte(input logic rdy,
                                             input logic busy,
                                             input logic cflag);
    return {4'b0000, cflag, 1'b0, busy, rdy};
  endfunction

endpackage

// File: rtl/idxp_host_side.sv
module idxp_host_side #(
  parameter int HAW         = 3,
  parameter int DW          = 8,
  parameter int DATA_OFS    = 0,
  parameter int CTRL_OFS    = 4,
  parameter int BUSY_CYCLES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HAW-1:0] host_addr,
  input  logic           host_wr,
  input  logic [DW-1:0]  host_wdata,
  output logic           ibf,
  output logic           cmd_flag,
  output logic           host_accept,
  output logic           pend_vld,
  output logic [DW-1:0]  pend_byte,
  output logic           pend_is_cmd
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] busy_cnt;
  logic          is_data;
  logic          is_ctrl;

  assign is_data     = (host_addr == HAW'(DATA_OFS));
  assign is_ctrl     = (host_addr == HAW'(CTRL_OFS));
  assign ibf         = (busy_cnt != '0);
  assign host_accept = host_wr && !ibf && (is_data || is_ctrl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt    <= '0;
      pend_vld    <= 1'b0;
      pend_byte   <= '0;
      pend_is_cmd <= 1'b0;
      cmd_flag    <= 1'b0;
    end else if (host_accept) begin
      busy_cnt    <= BUSY_LOAD;
      pend_vld    <= 1'b1;
      pend_byte   <= host_wdata;
      pend_is_cmd <= is_ctrl;
      cmd_flag    <= is_ctrl;
    end else begin
      pend_vld <= 1'b0;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/idxp_sequencer.sv
module idxp_sequencer
  import idxp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_vld,
  input  logic [DW-1:0] pend_byte,
  input  logic          pend_is_cmd,
  output logic          reg_rd_stb,
  output logic          reg_wr_stb,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output seq_state_t    seq_state
);

  seq_step_t step;

  always_comb begin
    step = seq_step(seq_state, pend_is_cmd, 8'(pend_byte));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_state  <= SQ_IDLE;
      reg_rd_stb <= 1'b0;
      reg_wr_stb <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
    end else begin
      reg_rd_stb <= 1'b0;
      reg_wr_stb <= 1'b0;
      if (pend_vld) begin
        seq_state  <= step.nxt;
        reg_rd_stb <= step.fire_rd;
        reg_wr_stb <= step.fire_wr;
        if (step.take_addr) reg_addr  <= AW'(pend_byte);
        if (step.take_data) reg_wdata <= pend_byte;
      end
    end
  end

endmodule

// File: rtl/idxp_out_buf.sv
module idxp_out_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_rd_stb,
  input  logic [DW-1:0] reg_rdata,
  input  logic          data_rd_evt,
  output logic          obf,
  output logic [DW-1:0] out_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf      <= 1'b0;
      out_byte <= '0;
    end else if (reg_rd_stb) begin
      obf      <= 1'b1;
      out_byte <= reg_rdata;
    end else if (data_rd_evt) begin
      obf <= 1'b0;
    end
  end

endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
  import idxp_pkg::*;
#(
  parameter int HAW         = 3,
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int DATA_OFS    = 0,
  parameter int CTRL_OFS    = 4,
  parameter int BUSY_CYCLES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HAW-1:0] host_addr,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic [AW-1:0]  reg_addr,
  output logic [DW-1:0]  reg_wdata,
  output logic           reg_wr_stb,
  output logic           reg_rd_stb,
  input  logic [DW-1:0]  reg_rdata
);

  logic          ibf;
  logic          obf;
  logic          cmd_flag;
  logic          host_accept;
  logic          data_rd_evt;
  logic          pend_vld;
  logic [DW-1:0] pend_byte;
  logic          pend_is_cmd;
  logic [DW-1:0] out_byte;
  seq_state_t    seq_state;

  assign data_rd_evt = host_rd && (host_addr == HAW'(DATA_OFS));

  idxp_host_side #(
    .HAW(HAW), .DW(DW), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .ibf(ibf), .cmd_flag(cmd_flag),
    .host_accept(host_accept), .pend_vld(pend_vld), .pend_byte(pend_byte),
    .pend_is_cmd(pend_is_cmd)
  );

  idxp_sequencer #(.DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_vld(pend_vld), .pend_byte(pend_byte),
    .pend_is_cmd(pend_is_cmd), .reg_rd_stb(reg_rd_stb),
    .reg_wr_stb(reg_wr_stb), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .seq_state(seq_state)
  );

  idxp_out_buf #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .reg_rd_stb(reg_rd_stb),
    .reg_rdata(reg_rdata), .data_rd_evt(data_rd_evt), .obf(obf),
    .out_byte(out_byte)
  );

  always_comb begin
    if (host_addr == HAW'(CTRL_OFS))
      host_rdata = DW'(status_byte(obf, ibf, cmd_flag));
    else if (host_addr == HAW'(DATA_OFS))
      host_rdata = out_byte;
    else
      host_rdata = '0;
  end

endmodule

// File: rtl/idxp_checker.sv
module idxp_checker #(
  parameter int HAW      = 3,
  parameter int CTRL_OFS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [HAW-1:0] host_addr,
  input logic           host_wr,
  input logic           host_accept,
  input logic           data_rd_evt,
  input logic           ibf,
  input logic           obf,
  input logic           cmd_flag,
  input logic           reg_rd_stb,
  input logic           reg_wr_stb
);

  p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_accept |=> ibf);

  // R4: a write during busy leaves the command flag alone
  p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && ibf) |=> $stable(cmd_flag));

  p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_stb |=> !reg_rd_stb);

  p_obf_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_stb |=> obf);

  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |=> !reg_wr_stb);

  p_obf_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_evt && !reg_rd_stb) |=> !obf);

  p_cflag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_accept && host_addr == HAW'(CTRL_OFS)) |=> cmd_flag);

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_stb && reg_wr_stb));

endmodule

bind idx_reg_port idxp_checker #(.HAW(HAW), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_accept(host_accept), .data_rd_evt(data_rd_evt), .ibf(ibf),
  .obf(obf), .cmd_flag(cmd_flag), .reg_rd_stb(reg_rd_stb),
  .reg_wr_stb(reg_wr_stb)
);

// File: tb/idx_reg_port_tb.sv
`timescale 1ns/1ps
module idx_reg_port_tb;

  localparam int BUSY = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr_stb;
  logic       reg_rd_stb;
  logic [7:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // stand-in register file behind the port
  logic [7:0] rfile [256];
  assign reg_rdata = rfile[reg_addr];
  always @(posedge clk) if (reg_wr_stb) rfile[reg_addr] <= reg_wdata;

  always #10 clk = ~clk;

  idx_reg_port #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr_stb(reg_wr_stb),
    .reg_rd_stb(reg_rd_stb), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h @%0t",
               req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_busy_left, m_mode, m_out;
  bit m_has_byte, m_byte_cmd, m_rd_now, m_wr_now, m_rdy, m_cflag;
  int m_byte, m_addr, m_data;
  int m_regs [256];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy_left = 0; m_mode = 0; m_out = 0; m_has_byte = 0;
      m_byte_cmd = 0; m_rd_now = 0; m_wr_now = 0; m_rdy = 0; m_cflag = 0;
      m_byte = 0; m_addr = 0; m_data = 0;
    end else begin
      bit took, was_rd, was_wr, was_has, was_cmd;
      int was_byte;
      was_rd = m_rd_now; was_wr = m_wr_now;
      was_has = m_has_byte; was_cmd = m_byte_cmd; was_byte = m_byte;
      took = host_wr && m_busy_left == 0 &&
             (host_addr == 3'd0 || host_addr == 3'd4);
      // result buffer
      if (was_rd) begin m_rdy = 1; m_out = m_regs[m_addr]; end
      else if (host_rd && host_addr == 3'd0) m_rdy = 0;
      if (was_wr) m_regs[m_addr] = m_data;
      // sequencing of the byte taken last cycle
      m_rd_now = 0; m_wr_now = 0;
      if (was_has) begin
        if (was_cmd)
          m_mode = (was_byte == 'h80) ? 1 : (was_byte == 'h81) ? 2 : 0;
        else if (m_mode == 1) begin m_addr = was_byte; m_rd_now = 1; m_mode = 0; end
        else if (m_mode == 2) begin m_addr = was_byte; m_mode = 3; end
        else if (m_mode == 3) begin m_data = was_byte; m_wr_now = 1; m_mode = 0; end
      end
      // host side
      m_has_byte = took;
      if (took) begin
        m_byte = host_wdata; m_byte_cmd = (host_addr == 3'd4);
        m_cflag = m_byte_cmd; m_busy_left = BUSY;
      end else if (m_busy_left > 0) m_busy_left--;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    int exp_rd;
    chk(u_dut.reg_rd_stb == m_rd_now, "R5 R12", "rd_stb", reg_rd_stb, m_rd_now);
    chk(reg_wr_stb == m_wr_now, "R6 R12", "wr_stb", reg_wr_stb, m_wr_now);
    if (m_rd_now) chk(reg_addr == m_addr, "R5", "rd addr", reg_addr, m_addr);
    if (m_wr_now) begin
      chk(reg_addr == m_addr, "R6", "wr addr", reg_addr, m_addr);
      chk(reg_wdata == m_data, "R6", "wr data", reg_wdata, m_data);
    end
    if (host_addr == 3'd4)
      exp_rd = (int'(m_cflag) << 3) | (int'(m_busy_left != 0) << 1) | int'(m_rdy);
    else if (host_addr == 3'd0) exp_rd = m_out;
    else exp_rd = 0;
    chk(host_rdata == exp_rd, "R2 R3 R7 R11", "host_rdata", host_rdata, exp_rd);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wbyte(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); #1;
    host_wr = 1'b0; host_addr = 3'd4;
  endtask

  task automatic gap(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wsend(input logic [2:0] a, input logic [7:0] d);
    wbyte(a, d); gap(BUSY);
  endtask

  task automatic rdata_read(output logic [7:0] v);
    host_addr = 3'd0; host_rd = 1'b1;
    #2 v = host_rdata;
    @(negedge clk); #1;
    host_rd = 1'b0; host_addr = 3'd4;
  endtask

  task automatic store(input logic [7:0] a, input logic [7:0] d);
    wsend(3'd4, 8'h81); wsend(3'd0, a); wsend(3'd0, d); gap(2);
  endtask

  task automatic fetch(input logic [7:0] a, input string req);
    logic [7:0] v;
    wsend(3'd4, 8'h80); wsend(3'd0, a); gap(2);
    chk(host_rdata[0] == 1'b1, req, "result-ready before read", host_rdata, 1);
    rdata_read(v);
    chk(v == 8'(m_regs[a]), req, "fetched value", v, m_regs[a]);
    #2 chk(host_rdata[0] == 1'b0, "R7", "result-ready after read", host_rdata, 0);
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      rfile[i] = 8'(i * 7 + 3);
      m_regs[i] = (i * 7 + 3) & 'hff;
    end
    host_addr = 3'd4;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    #2;
    // R1: reset state
    chk(host_rdata == 8'h00, "R1", "status after reset", host_rdata, 0);
    chk(!reg_rd_stb && !reg_wr_stb, "R1", "strobes after reset",
        {reg_rd_stb, reg_wr_stb}, 0);
    gap(1);

    // R2: unused offset reads 0 and ignores writes
    wbyte(3'd2, 8'h81);
    #2 chk(host_rdata == 8'h00, "R2", "status after bad-offset write", host_rdata, 0);
    host_addr = 3'd6; #1;
    chk(host_rdata == 8'h00, "R2", "unused offset read", host_rdata, 0);
    host_addr = 3'd4; gap(1);

    // R3 R11: busy timing and command flag
    wbyte(3'd4, 8'h55);
    #2 chk(host_rdata == 8'h0A, "R3 R11", "busy+cflag after cmd", host_rdata, 8'h0A);
    gap(BUSY);
    chk(host_rdata[1] == 1'b0, "R3", "busy clear", host_rdata, 0);

    // R6 then R5: store and fetch
    store(8'h10, 8'hA5);
    fetch(8'h10, "R5");
    store(8'hFF, 8'h3C);
    fetch(8'hFF, "R6");
    fetch(8'h00, "R5");

    // R8: stray data byte with no command
    wsend(3'd0, 8'h22); gap(2);
    chk(host_rdata[3] == 1'b0, "R11", "cflag cleared by data write", host_rdata, 0);
    fetch(8'h22, "R8");

    // R4: write during busy is dropped
    wbyte(3'd4, 8'h81);
    wbyte(3'd0, 8'h40);
    gap(BUSY);
    wsend(3'd0, 8'h41); wsend(3'd0, 8'h99); gap(2);
    fetch(8'h41, "R4");
    fetch(8'h40, "R4");

    // R9: abort a store after its address byte
    wsend(3'd4, 8'h81); wsend(3'd0, 8'h30);
    wsend(3'd4, 8'h80); wsend(3'd0, 8'h31); gap(2);
    fetch(8'h30, "R9");

    // R10: unknown command then data bytes
    wsend(3'd4, 8'h81); wsend(3'd4, 8'h7E);
    wsend(3'd0, 8'h50); wsend(3'd0, 8'h66); gap(2);
    fetch(8'h50, "R10");

    // R7: result captured with no read keeps ready set
    wsend(3'd4, 8'h80); wsend(3'd0, 8'h05); gap(4);
    chk(host_rdata[0] == 1'b1, "R7", "ready holds without read", host_rdata, 1);
    gap(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule